// File: doc/BRIEF.md
# Always-On Tick Counter Register Block

This block is a memory-mapped real-time counter for a simple 32-bit register bus. It keeps a 47-bit count that advances by one on each strobe of a 32,768 Hz time base, so one unit of the count is 1/32768 second. Software sees the count as two registers. The upper register carries the top 15 bits and the lower register carries the bottom 32 bits. Software can read either half and can overwrite either half without disturbing the other.

A control register holds software settings and reads back whatever was last written to it. A single control write that sets both the power-down enable bit and the turn-off bit makes the block emit a one-cycle shutdown request, which system power logic uses to remove power. The count has no reset: a bus reset clears the control register and the read data, but it leaves the time value intact.

The bus uses a request strobe, a write enable, a 12-bit byte address inside a 4 KB window and 32-bit data. Read data appears one cycle after the request and holds until the next read.

Top module: `aon_rtc_regs`

## Requirements
- R1: Each cycle with tick_i high and no count write, the 47-bit count increases by one, and it wraps from all-ones to zero.
- R2: A read at byte offset 0x50 returns count bits 46:32 in rdata bits 14:0, with rdata bits 31:15 zero.
- R3: A read at byte offset 0x54 returns count bits 31:0.
- R4: A write at 0x50 loads count bits 46:32 from wdata bits 14:0, ignores wdata bits 31:15 and keeps bits 31:0. A write at 0x54 loads bits 31:0 and keeps bits 46:32.
- R5: When a count write and a tick fall in the same cycle, the count takes the written value with the other half unchanged, and that tick is dropped.
- R6: The control register at offset 0x34 reads back the last 32-bit value written to it, and it is zero after reset.
- R7: Asserting rst_ni low does not change the count.
- R8: shutdown_o is high for exactly the one cycle after an accepted control write whose wdata has bit 5 (power-down enable) and bit 6 (turn-off) both set. A control write with only one of the two bits set produces no pulse.
- R9: An access with addr_i bits 1:0 not zero is ignored: writes change nothing and reads return zero. Reads of any offset other than 0x34, 0x50 and 0x54 return zero, and writes to such offsets change nothing.
- R10: rdata_o is updated on the clock edge that takes a read request, with register values from before that edge. It keeps its value through cycles without a read and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 32,768 Hz time-base strobe, synchronous to clk_i |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the 4 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| shutdown_o | output | 1 | One-cycle system power-off request |

## Verification
Any error in the count is visible on the next read of either half. A dropped or doubled increment shows up as an off-by-one in the low word. A bad carry or a corrupted write shows up as a wrong high word, and that faulty value then persists across reset. A control register that does not hold its value is caught by a read-back one cycle later. A decode error that leaks misaligned or unassigned accesses into a register produces either a non-zero read of a hole or a changed value at a real offset. A fault in the shutdown qualifier shows on shutdown_o in the cycle right after the write, as a missing pulse, a pulse that is too long, or a pulse that should not be there.

// File: rtl/aon_rtc_pkg.sv
package aon_rtc_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTRL = 2'd1,
    RD_HI   = 2'd2,
    RD_LO   = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/aon_bus_decode.sv
module aon_bus_decode
  import aon_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [11:0] OFS_CTRL = 12'h034,
  parameter logic [11:0] OFS_HI   = 12'h050,
  parameter logic [11:0] OFS_LO   = 12'h054
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_ctrl_o,
  output logic              wr_hi_o,
  output logic              wr_lo_o,
  output logic              rd_o,
  output rd_sel_e           rd_sel_o
);
  logic    aligned;
  rd_sel_e sel;

  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    sel = RD_NONE;
    if (aligned) begin
      if (addr_i == ADDR_W'(OFS_CTRL))    sel = RD_CTRL;
      else if (addr_i == ADDR_W'(OFS_HI)) sel = RD_HI;
      else if (addr_i == ADDR_W'(OFS_LO)) sel = RD_LO;
    end
  end

  assign wr_ctrl_o = req_i && we_i && (sel == RD_CTRL);
  assign wr_hi_o   = req_i && we_i && (sel == RD_HI);
  assign wr_lo_o   = req_i && we_i && (sel == RD_LO);
  assign rd_o      = req_i && !we_i;
  assign rd_sel_o  = sel;

  // R9
  wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_ctrl_o, wr_hi_o, wr_lo_o}));
  // R9
  misaligned_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |-> !(wr_ctrl_o || wr_hi_o || wr_lo_o));
endmodule

// File: rtl/aon_count_core.sv
module aon_count_core #(
  parameter int unsigned CNT_W  = 47,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LO_W  = DATA_W,
  localparam int unsigned HI_W  = CNT_W - LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [HI_W-1:0]   cnt_hi_o,
  output logic [LO_W-1:0]   cnt_lo_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // write beats tick; halves load independently
  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo_i)      cnt_d = {cnt_q[CNT_W-1:LO_W], wdata_i};
    else if (wr_hi_i) cnt_d = {wdata_i[HI_W-1:0], cnt_q[LO_W-1:0]};
    else if (tick_i)  cnt_d = cnt_q + CNT_W'(1);
  end

  // no reset: time survives a bus reset
  always_ff @(posedge clk_i) cnt_q <= cnt_d;

  assign cnt_hi_o = cnt_q[CNT_W-1:LO_W];
  assign cnt_lo_o = cnt_q[LO_W-1:0];

  // R1
  tick_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_hi_i && !wr_lo_i) |=> ({cnt_hi_o, cnt_lo_o} == $past({cnt_hi_o, cnt_lo_o}) + CNT_W'(1)));
  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_hi_i && !wr_lo_i) |=> $stable({cnt_hi_o, cnt_lo_o}));
  // R4
  lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (cnt_lo_o == $past(wdata_i)) && $stable(cnt_hi_o));
  // R4
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (cnt_hi_o == $past(wdata_i[HI_W-1:0])) && $stable(cnt_lo_o));
endmodule

// File: rtl/aon_ctrl_reg.sv
module aon_ctrl_reg #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PDEN_BIT = 5,
  parameter int unsigned OFF_BIT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              shutdown_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic              sd_q;
  logic              kill_req;

  assign kill_req = wr_i && wdata_i[PDEN_BIT] && wdata_i[OFF_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sd_q   <= 1'b0;
    end else begin
      if (wr_i) ctrl_q <= wdata_i;
      sd_q <= kill_req;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign shutdown_o = sd_q;

  // R6
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_o));
  // R8
  sd_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> $past(wr_i && wdata_i[PDEN_BIT] && wdata_i[OFF_BIT]));
  // R8
  sd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && wdata_i[PDEN_BIT] && wdata_i[OFF_BIT]) |=> !shutdown_o);
endmodule

// File: rtl/aon_rtc_regs.sv
module aon_rtc_regs
  import aon_rtc_pkg::*;
#(
  parameter int unsigned CNT_W    = 47,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [11:0] OFS_CTRL = 12'h034,
  parameter logic [11:0] OFS_HI   = 12'h050,
  parameter logic [11:0] OFS_LO   = 12'h054,
  parameter int unsigned PDEN_BIT = 5,
  parameter int unsigned OFF_BIT  = 6,
  localparam int unsigned HI_W    = CNT_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              shutdown_o
);
  logic              wr_ctrl, wr_hi, wr_lo, rd;
  rd_sel_e           rd_sel;
  logic [HI_W-1:0]   cnt_hi;
  logic [DATA_W-1:0] cnt_lo, ctrl, rd_mux, rdata_q;

  aon_bus_decode #(
    .ADDR_W(ADDR_W), .OFS_CTRL(OFS_CTRL), .OFS_HI(OFS_HI), .OFS_LO(OFS_LO)
  ) u_dec (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .wr_ctrl_o(wr_ctrl), .wr_hi_o(wr_hi), .wr_lo_o(wr_lo),
    .rd_o(rd), .rd_sel_o(rd_sel)
  );

  aon_count_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wdata_i,
    .cnt_hi_o(cnt_hi), .cnt_lo_o(cnt_lo)
  );

  aon_ctrl_reg #(.DATA_W(DATA_W), .PDEN_BIT(PDEN_BIT), .OFF_BIT(OFF_BIT)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr_ctrl), .wdata_i,
    .ctrl_o(ctrl), .shutdown_o
  );

  always_comb begin
    unique case (rd_sel)
      RD_CTRL: rd_mux = ctrl;
      RD_HI:   rd_mux = DATA_W'(cnt_hi);
      RD_LO:   rd_mux = cnt_lo;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  // R9
  hole_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[1:0] != 2'b00) |=> (rdata_o == '0));
  // R2
  hi_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFS_HI)) |=> (rdata_o[DATA_W-1:HI_W] == '0));
endmodule

// File: tb/aon_rtc_regs_tb.sv
module aon_rtc_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h034, A_HI = 12'h050, A_LO = 12'h054;

  logic        clk_i = 0, rst_ni = 0, tick_i = 0, req_i = 0, we_i = 0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        shutdown_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [46:0] m_cnt = '0;
  logic [31:0] m_ctrl = '0, m_rd = '0;
  logic        m_sd = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  aon_rtc_regs u_dut (.*);

  function automatic logic [31:0] model_read(logic [11:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a == A_CTRL) return m_ctrl;
    if (a == A_HI)   return {17'h0, m_cnt[46:32]};
    if (a == A_LO)   return m_cnt[31:0];
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive, predict, sample after the edge
  task automatic cyc(input logic rq, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic tk, input string tag);
    logic al;
    req_i = rq; we_i = w; addr_i = a; wdata_i = d; tick_i = tk;
    al = (a[1:0] == 2'b00);
    if (rq && !w) m_rd = model_read(a);
    m_sd = rq && w && al && (a == A_CTRL) && d[5] && d[6];
    if (rq && w && al && a == A_LO)      m_cnt = {m_cnt[46:32], d};
    else if (rq && w && al && a == A_HI) m_cnt = {d[14:0], m_cnt[31:0]};
    else if (tk)                         m_cnt = m_cnt + 47'd1;
    if (rq && w && al && a == A_CTRL)    m_ctrl = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0; we_i = 0; tick_i = 0;
    chk({tag, " rdata"}, rdata_o, m_rd);
    chk({tag, " shutdown"}, {31'h0, shutdown_o}, {31'h0, m_sd});
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1, 0, a, 32'h0, 0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1, 1, a, d, 0, tag);
  endtask

  task automatic do_reset();
    rst_ni = 0; tick_i = 0; req_i = 0;
    repeat (3) @(negedge clk_i);
    m_ctrl = '0; m_rd = '0; m_sd = 0;
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk_i);
    do_reset();
    // R6 R10 reset state
    chk("R10 rdata after reset", rdata_o, 32'h0);
    rd(A_CTRL, "R6 ctrl after reset");
    chk("R8 no shutdown after reset", {31'h0, shutdown_o}, 32'h0);

    // R4 load halves, R2/R3 read back
    wr(A_LO, 32'hDEAD_BEEF, "R4 wr lo");
    wr(A_HI, 32'hFFFF_1234, "R4 wr hi ignores upper bits");
    rd(A_HI, "R2 hi read");
    chk("R2 hi upper zero", rdata_o, 32'h0000_1234);
    rd(A_LO, "R3 lo read");
    chk("R4 lo kept after hi write", rdata_o, 32'hDEAD_BEEF);
    wr(A_LO, 32'h0000_0010, "R4 wr lo again");
    rd(A_HI, "R4 hi kept after lo write");

    // R1 ticks and carry into high half
    for (int i = 0; i < 5; i++) cyc(0, 0, 12'h0, 32'h0, 1, "R1 tick");
    rd(A_LO, "R1 lo after 5 ticks");
    chk("R1 lo value", rdata_o, 32'h15);
    wr(A_LO, 32'hFFFF_FFFF, "R1 preset lo");
    cyc(0, 0, 12'h0, 32'h0, 1, "R1 carry tick");
    rd(A_HI, "R1 carry into hi");
    chk("R1 hi after carry", rdata_o, 32'h1235);
    wr(A_HI, 32'h0000_7FFF, "R1 preset hi all ones");
    wr(A_LO, 32'hFFFF_FFFF, "R1 preset lo all ones");
    cyc(0, 0, 12'h0, 32'h0, 1, "R1 wrap tick");
    rd(A_LO, "R1 wrap lo");
    chk("R1 wrap lo zero", rdata_o, 32'h0);
    rd(A_HI, "R1 wrap hi");
    chk("R1 wrap hi zero", rdata_o, 32'h0);

    // R5 write collides with tick
    cyc(1, 1, A_LO, 32'h0000_0100, 1, "R5 lo write with tick");
    rd(A_LO, "R5 lo write wins");
    chk("R5 no increment", rdata_o, 32'h100);
    cyc(1, 1, A_HI, 32'h0000_0042, 1, "R5 hi write with tick");
    rd(A_LO, "R5 lo untouched by hi write+tick");
    rd(A_HI, "R5 hi write wins");

    // R6 control readback
    wr(A_CTRL, 32'hA5A5_5A1F, "R6 ctrl write");
    rd(A_CTRL, "R6 ctrl readback");
    // R8 only one bit, then both
    wr(A_CTRL, 32'h0000_0020, "R8 pden only");
    wr(A_CTRL, 32'h0000_0040, "R8 off only");
    wr(A_CTRL, 32'h0000_0060, "R8 both bits");
    chk("R8 pulse high", {31'h0, shutdown_o}, 32'h1);
    cyc(0, 0, 12'h0, 32'h0, 0, "R8 pulse one cycle");
    wr(A_CTRL, 32'hFFFF_FFFF, "R8 all bits");
    wr(A_CTRL, 32'hFFFF_FFFF, "R8 back-to-back");

    // R9 misaligned and holes
    wr(A_LO | 12'h1, 32'h1234_5678, "R9 misaligned lo write");
    wr(A_CTRL | 12'h2, 32'h0000_0060, "R9 misaligned ctrl write");
    wr(12'h058, 32'hFFFF_FFFF, "R9 hole write");
    rd(A_LO, "R9 lo unchanged");
    rd(A_CTRL, "R9 ctrl unchanged");
    rd(A_HI | 12'h3, "R9 misaligned read zero");
    rd(12'hFFC, "R9 hole read zero");
    rd(12'h000, "R9 offset zero read");

    // R7 reset keeps count
    wr(A_HI, 32'h0000_3C3C, "R7 preset hi");
    wr(A_LO, 32'h8765_4321, "R7 preset lo");
    do_reset();
    rd(A_LO, "R7 lo survives reset");
    rd(A_HI, "R7 hi survives reset");
    rd(A_CTRL, "R6 ctrl cleared by reset");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 7);
      case (sel)
        0, 1:    a = A_LO;
        2, 3:    a = A_HI;
        4, 5:    a = A_CTRL;
        6:       a = 12'($urandom_range(0, 4095));
        default: a = A_LO | 12'($urandom_range(1, 3));
      endcase
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d[6:5] = 2'b11;
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, d,
          $urandom_range(0, 1) == 1, "R10 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule